// File: doc/BRIEF.md
# Raster-to-Tiled Address Generator

This block turns a rectangular pixel region into two parallel byte-address streams. A single start command gives the region's top-left corner, its width and height, the bytes per pixel, the row pitch of a linear buffer and the pitch of one row of tiles in a tiled surface. The block then visits every pixel, row by row from the top and left to right within each row. For each pixel it emits the byte address that pixel has in the tiled surface and the byte address it has in the linear buffer. A copy engine uses the two addresses to move a pixel in either direction.

The tiled surface is cut into 16x16-pixel tiles of 256 pixels each. Tiles in one tile row are packed back to back. Inside a tile the pixel slot comes from interleaving the low four bits of X and Y, with an XOR applied to each pair of bits. The Y part of that slot depends only on the row, so it is computed once each time a new row begins. The region's origin and width do not have to be multiples of 16, because every pixel's address is formed from its own coordinates.

A test input makes the in-tile slot plain row-major, so the stream can be compared against a simple model. The output uses a valid/ready handshake and flags the final pixel. A done pulse follows the final handshake, and an error pulse reports a start command that was refused.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_valid`, `addr_done` and `cmd_err` are 0 and `cmd_ready` is 1.
- R2: An accepted start command makes `addr_valid` rise in the next cycle. One beat is produced per pixel, width times height beats in all, in raster order. `addr_last` is 1 on the final beat only.
- R3: With the swizzle active, the 8-bit in-tile slot from bit 7 down to bit 0 is y3, x3^y3, y2, x2^y2, y1, x1^y1, y0, x0^y0. Here x and y are the low four bits of the pixel's absolute coordinates.
- R4: `tiled_addr` = (y with its low 4 bits cleared) * tile_pitch + bpp * ((x >> 4) * 256 + slot).
- R5: `lin_addr` = (y - y0) * lin_pitch + bpp * (x - x0), where (x0, y0) is the region origin.
- R6: A bpp of 1, 2, 3, 4, 6, 8, 12 or 16 is accepted. Any other value sets `cmd_err` for one cycle, the cycle after the command, and no beat is produced.
- R7: A start command with width 0 or height 0 is refused in the same way as in R6.
- R8: While `addr_valid` is 1 and `addr_ready` is 0, the addresses and `addr_last` hold their values and `addr_valid` stays 1.
- R9: `addr_done` is 1 for exactly the one cycle after the beat that carries `addr_last` is accepted. `cmd_ready` is 1 again in that cycle.
- R10: When `cmd_bypass` is 1 on the start command, the slot is y[3:0]*16 + x[3:0] for that whole region.
- R11: The origin and the width may have any value, not only multiples of 16. Pixels on either side of a tile boundary get the addresses given by R4.
- R12: While a region is being walked, `cmd_ready` is 0 and start commands are ignored. The stream in progress is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Start command present |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_x0 | input | 16 | Region origin X |
| cmd_y0 | input | 16 | Region origin Y |
| cmd_width | input | 16 | Region width in pixels |
| cmd_height | input | 16 | Region height in pixels |
| cmd_tile_pitch | input | 24 | Bytes per pixel row in the tiled surface |
| cmd_lin_pitch | input | 24 | Bytes per row in the linear buffer |
| cmd_bpp | input | 5 | Bytes per pixel |
| cmd_bypass | input | 1 | Use the plain row-major in-tile slot |
| cmd_err | output | 1 | One-cycle pulse for a refused command |
| addr_valid | output | 1 | Address beat present |
| addr_ready | input | 1 | Consumer takes the beat |
| tiled_addr | output | 32 | Byte address in the tiled surface |
| lin_addr | output | 32 | Byte address in the linear buffer |
| addr_last | output | 1 | Beat is the final pixel of the region |
| addr_done | output | 1 | One-cycle pulse after the final beat |

## Verification
The properties assume that region coordinates plus extent fit in 16 bits and that every address fits in 32 bits, so nothing wraps. The stimulus keeps origins below 64, extents below 40 and pitches at a few kilobytes to stay inside that range. The properties also assume that `addr_ready` may fall at any time and that start commands may arrive while a region is being walked. The bench drives random back-pressure and stray start commands during every region to exercise both.

// File: rtl/tile_addr_pkg.sv
// Shared constants, types and helper functions for the tiled address generator.
// Assumes a fixed 16x16 tile, so the in-tile slot is always 8 bits.
package tile_addr_pkg;

    localparam int TILE_LOG2 = 4;
    localparam int SLOT_W    = 2 * TILE_LOG2;
    localparam int BPP_W     = 5;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_t;

    // True for the pixel sizes the copy engine supports.
    function automatic logic bpp_supported(input logic [BPP_W-1:0] b);
        logic ok;
        case (b)
            5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16: ok = 1'b1;
            default:                                          ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Copies each bit of a nibble into an adjacent pair of bits.
    function automatic logic [SLOT_W-1:0] pair_up(input logic [TILE_LOG2-1:0] n);
        logic [SLOT_W-1:0] r;
        for (int i = 0; i < TILE_LOG2; i++) begin
            r[2*i]   = n[i];
            r[2*i+1] = n[i];
        end
        return r;
    endfunction

    // Places the bits of a nibble on the even positions, with zeros between them.
    function automatic logic [SLOT_W-1:0] spread_even(input logic [TILE_LOG2-1:0] n);
        logic [SLOT_W-1:0] r;
        for (int i = 0; i < TILE_LOG2; i++) begin
            r[2*i]   = n[i];
            r[2*i+1] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tile_row_term.sv
// Builds the part of the in-tile slot that depends on the row only.
// Swizzled mode: the Y nibble with each bit doubled. Bypass mode: Y nibble
// shifted into the high half. Purely combinational; the caller registers it.
module tile_row_term
    import tile_addr_pkg::*;
(
    input  logic [TILE_LOG2-1:0] y_nib,
    input  logic                 bypass,
    output logic [SLOT_W-1:0]    term
);

    // Select the row contribution for the requested slot layout.
    always_comb begin
        if (bypass) term = {y_nib, {TILE_LOG2{1'b0}}};
        else        term = pair_up(y_nib);
    end

endmodule

// File: rtl/tile_slot_mix.sv
// Merges the registered row term with the pixel's X nibble into the 8-bit slot.
// Swizzled mode XORs the X bits onto the even positions; bypass mode ORs the
// X nibble into the low half, which the row term leaves at zero.
module tile_slot_mix
    import tile_addr_pkg::*;
(
    input  logic [SLOT_W-1:0]    row_term,
    input  logic [TILE_LOG2-1:0] x_nib,
    input  logic                 bypass,
    output logic [SLOT_W-1:0]    slot
);

    // Combine the row part and the column part of the slot.
    always_comb begin
        if (bypass) slot = row_term | {{TILE_LOG2{1'b0}}, x_nib};
        else        slot = row_term ^ spread_even(x_nib);
    end

endmodule

// File: rtl/tile_region_walker.sv
// Sequencer: checks the start command, then steps a relative (rx, ry) counter
// through the region in raster order, one step per accepted beat.
// Assumes the consumer may stall at any time. Produces the done and error pulses.
module tile_region_walker
    import tile_addr_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic [COORD_W-1:0] start_w,
    input  logic [COORD_W-1:0] start_h,
    input  logic [BPP_W-1:0]   start_bpp,
    output logic               start_ready,
    output logic               start_take,
    input  logic               beat_ready,
    output logic               beat_valid,
    output logic               beat_last,
    output logic               row_step,
    output logic [COORD_W-1:0] rx,
    output logic [COORD_W-1:0] ry,
    output logic               done_pulse,
    output logic               err_pulse
);

    walk_state_t        state;
    logic [COORD_W-1:0] w_r;
    logic [COORD_W-1:0] h_r;
    logic               cmd_ok;
    logic               start_fire;
    logic               beat_fire;
    logic               row_end;

    // Decode handshakes and the region-end conditions.
    always_comb begin
        cmd_ok      = bpp_supported(start_bpp) && (start_w != '0) && (start_h != '0);
        start_ready = (state == WALK_IDLE);
        start_fire  = start_valid && start_ready;
        start_take  = start_fire && cmd_ok;
        beat_valid  = (state == WALK_RUN);
        beat_fire   = beat_valid && beat_ready;
        row_end     = (rx == w_r - COORD_W'(1));
        beat_last   = beat_valid && row_end && (ry == h_r - COORD_W'(1));
        row_step    = beat_fire && row_end && !beat_last;
    end

    // Sequence state, counters and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WALK_IDLE;
            rx         <= '0;
            ry         <= '0;
            w_r        <= '0;
            h_r        <= '0;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (start_take) begin
                        state <= WALK_RUN;
                        rx    <= '0;
                        ry    <= '0;
                        w_r   <= start_w;
                        h_r   <= start_h;
                    end else if (start_fire) begin
                        err_pulse <= 1'b1;
                    end
                end
                WALK_RUN: begin
                    if (beat_fire) begin
                        if (beat_last) begin
                            state      <= WALK_IDLE;
                            done_pulse <= 1'b1;
                        end else if (row_end) begin
                            rx <= '0;
                            ry <= ry + COORD_W'(1);
                        end else begin
                            rx <= rx + COORD_W'(1);
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tile_addr_calc.sv
// Forms both byte addresses of the current pixel from the latched configuration,
// the absolute and relative coordinates and the in-tile slot.
// Assumes the results fit in ADDR_W bits; higher bits are dropped.
module tile_addr_calc
    import tile_addr_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int STRIDE_W = 24,
    parameter int ADDR_W   = 32
) (
    input  logic [COORD_W-1:0]  abs_x,
    input  logic [COORD_W-1:0]  abs_y,
    input  logic [COORD_W-1:0]  rel_x,
    input  logic [COORD_W-1:0]  rel_y,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [STRIDE_W-1:0] tile_pitch,
    input  logic [STRIDE_W-1:0] lin_pitch,
    input  logic [BPP_W-1:0]    bpp,
    output logic [ADDR_W-1:0]   tiled_addr,
    output logic [ADDR_W-1:0]   lin_addr
);

    localparam int TILE_PIX_LOG2 = 2 * TILE_LOG2;

    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] pix_in_row;
    logic [ADDR_W-1:0] bpp_x;

    // Tile-row base, pixel offset inside the tile row, then scale by pixel size.
    always_comb begin
        bpp_x      = ADDR_W'(bpp);
        row_base   = ADDR_W'({abs_y[COORD_W-1:TILE_LOG2], {TILE_LOG2{1'b0}}})
                     * ADDR_W'(tile_pitch);
        pix_in_row = (ADDR_W'(abs_x[COORD_W-1:TILE_LOG2]) << TILE_PIX_LOG2)
                     + ADDR_W'(slot);
        tiled_addr = row_base + bpp_x * pix_in_row;
        lin_addr   = ADDR_W'(rel_y) * ADDR_W'(lin_pitch) + bpp_x * ADDR_W'(rel_x);
    end

endmodule

// File: rtl/tile_addr_gen.sv
// Top level: latches a start command, drives the raster walker and emits a
// tiled and a linear byte address per pixel over a valid/ready stream.
// The row term of the in-tile slot is registered once per row. Outputs are
// functions of registered state only, so they hold while the consumer stalls.
module tile_addr_gen
    import tile_addr_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int STRIDE_W = 24,
    parameter int ADDR_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [COORD_W-1:0]  cmd_x0,
    input  logic [COORD_W-1:0]  cmd_y0,
    input  logic [COORD_W-1:0]  cmd_width,
    input  logic [COORD_W-1:0]  cmd_height,
    input  logic [STRIDE_W-1:0] cmd_tile_pitch,
    input  logic [STRIDE_W-1:0] cmd_lin_pitch,
    input  logic [4:0]          cmd_bpp,
    input  logic                cmd_bypass,
    output logic                cmd_err,
    output logic                addr_valid,
    input  logic                addr_ready,
    output logic [ADDR_W-1:0]   tiled_addr,
    output logic [ADDR_W-1:0]   lin_addr,
    output logic                addr_last,
    output logic                addr_done
);

    logic [COORD_W-1:0]  x0_r;
    logic [COORD_W-1:0]  y0_r;
    logic [STRIDE_W-1:0] tpitch_r;
    logic [STRIDE_W-1:0] lpitch_r;
    logic [BPP_W-1:0]    bpp_r;
    logic                bypass_r;
    logic [SLOT_W-1:0]   row_term_r;

    logic                start_take;
    logic                row_step;
    logic [COORD_W-1:0]  rx;
    logic [COORD_W-1:0]  ry;
    logic [COORD_W-1:0]  cx;
    logic [COORD_W-1:0]  cy;
    logic [COORD_W-1:0]  cy_next;
    logic [TILE_LOG2-1:0] term_y_sel;
    logic                term_byp_sel;
    logic [SLOT_W-1:0]   term_next;
    logic [SLOT_W-1:0]   slot;

    tile_region_walker #(.COORD_W(COORD_W)) walker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (cmd_valid),
        .start_w     (cmd_width),
        .start_h     (cmd_height),
        .start_bpp   (cmd_bpp),
        .start_ready (cmd_ready),
        .start_take  (start_take),
        .beat_ready  (addr_ready),
        .beat_valid  (addr_valid),
        .beat_last   (addr_last),
        .row_step    (row_step),
        .rx          (rx),
        .ry          (ry),
        .done_pulse  (addr_done),
        .err_pulse   (cmd_err)
    );

    // Absolute coordinates of the current pixel and of the next row.
    always_comb begin
        cx      = x0_r + rx;
        cy      = y0_r + ry;
        cy_next = cy + COORD_W'(1);
    end

    // Pick the row whose term is loaded next: the origin row or the following row.
    always_comb begin
        if (start_take) begin
            term_y_sel   = cmd_y0[TILE_LOG2-1:0];
            term_byp_sel = cmd_bypass;
        end else begin
            term_y_sel   = cy_next[TILE_LOG2-1:0];
            term_byp_sel = bypass_r;
        end
    end

    tile_row_term row_term_i (
        .y_nib  (term_y_sel),
        .bypass (term_byp_sel),
        .term   (term_next)
    );

    // Latch the command configuration when a valid start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0_r     <= '0;
            y0_r     <= '0;
            tpitch_r <= '0;
            lpitch_r <= '0;
            bpp_r    <= '0;
            bypass_r <= 1'b0;
        end else if (start_take) begin
            x0_r     <= cmd_x0;
            y0_r     <= cmd_y0;
            tpitch_r <= cmd_tile_pitch;
            lpitch_r <= cmd_lin_pitch;
            bpp_r    <= cmd_bpp;
            bypass_r <= cmd_bypass;
        end
    end

    // Refresh the row term at region start and at each new row only.
    always_ff @(posedge clk) begin
        if (!rst_n)                      row_term_r <= '0;
        else if (start_take || row_step) row_term_r <= term_next;
    end

    tile_slot_mix slot_i (
        .row_term (row_term_r),
        .x_nib    (cx[TILE_LOG2-1:0]),
        .bypass   (bypass_r),
        .slot     (slot)
    );

    tile_addr_calc #(
        .COORD_W  (COORD_W),
        .STRIDE_W (STRIDE_W),
        .ADDR_W   (ADDR_W)
    ) calc_i (
        .abs_x      (cx),
        .abs_y      (cy),
        .rel_x      (rx),
        .rel_y      (ry),
        .slot       (slot),
        .tile_pitch (tpitch_r),
        .lin_pitch  (lpitch_r),
        .bpp        (bpp_r),
        .tiled_addr (tiled_addr),
        .lin_addr   (lin_addr)
    );

endmodule

// File: rtl/tile_addr_gen_chk.sv
// Protocol checker for tile_addr_gen, attached by bind. Watches ports only.
module tile_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              cmd_err,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] tiled_addr,
    input logic [ADDR_W-1:0] lin_addr,
    input logic              addr_last,
    input logic              addr_done
);

    // R8: a stalled beat keeps its payload and stays valid.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(tiled_addr)
                                         && $stable(lin_addr) && $stable(addr_last)));

    // R9: done follows an accepted final beat and finds the block idle.
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> ($past(addr_valid && addr_ready && addr_last) && cmd_ready));

    // R9: a done pulse lasts one cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> !addr_done);

    // R6: a refused command produces no beat.
    a_r6_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!addr_valid && cmd_ready));

    // R12: no command is taken while beats are pending.
    a_r12_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> !cmd_ready);

    // R2: the last flag only rides on a valid beat.
    a_r2_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .cmd_err    (cmd_err),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .tiled_addr (tiled_addr),
    .lin_addr   (lin_addr),
    .addr_last  (addr_last),
    .addr_done  (addr_done)
);

// File: tb/tile_addr_gen_tb_top.sv
`timescale 1ns/1ps
module tile_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_x0 = '0;
    logic [15:0] cmd_y0 = '0;
    logic [15:0] cmd_width = '0;
    logic [15:0] cmd_height = '0;
    logic [23:0] cmd_tile_pitch = '0;
    logic [23:0] cmd_lin_pitch = '0;
    logic [4:0]  cmd_bpp = '0;
    logic        cmd_bypass = 1'b0;
    logic        cmd_err;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] tiled_addr;
    logic [31:0] lin_addr;
    logic        addr_last;
    logic        addr_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tile_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_x0(cmd_x0), .cmd_y0(cmd_y0),
        .cmd_width(cmd_width), .cmd_height(cmd_height),
        .cmd_tile_pitch(cmd_tile_pitch), .cmd_lin_pitch(cmd_lin_pitch),
        .cmd_bpp(cmd_bpp), .cmd_bypass(cmd_bypass), .cmd_err(cmd_err),
        .addr_valid(addr_valid), .addr_ready(addr_ready),
        .tiled_addr(tiled_addr), .lin_addr(lin_addr),
        .addr_last(addr_last), .addr_done(addr_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Slot from the bit-order rule, written bit by bit (R3), or row-major (R10).
    function automatic int exp_slot(input int x, input int y, input bit byp);
        bit [7:0] s;
        if (byp) return (y % 16) * 16 + (x % 16);
        for (int i = 0; i < 4; i++) begin
            s[2*i+1] = y[i];
            s[2*i]   = x[i] ^ y[i];
        end
        return int'(s);
    endfunction

    function automatic longint exp_tiled(input int x, input int y, input int tp,
                                         input int bpp, input bit byp);
        return longint'(y / 16 * 16) * tp + longint'(bpp) * ((x / 16) * 256 + exp_slot(x, y, byp));
    endfunction

    function automatic int pick_bpp(input int sel);
        case (sel % 8)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;
            4: return 6;  5: return 8;  6: return 12; default: return 16;
        endcase
    endfunction

    // Walk one region with random stalls and stray commands; check every beat.
    task automatic run_region(input int x0, input int y0, input int w, input int h,
                              input int tp, input int lp, input int bpp,
                              input bit byp, input int stall_pct);
        int k;
        int total;
        bit held;
        longint hold_t;
        longint hold_l;
        bit hold_last;
        @(negedge clk);
        cmd_x0 = 16'(x0); cmd_y0 = 16'(y0);
        cmd_width = 16'(w); cmd_height = 16'(h);
        cmd_tile_pitch = 24'(tp); cmd_lin_pitch = 24'(lp);
        cmd_bpp = 5'(bpp); cmd_bypass = byp; cmd_valid = 1'b1;
        @(negedge clk);
        k = 0; total = w * h; held = 1'b0;
        while (k < total) begin
            addr_ready = (($urandom % 100) >= stall_pct);
            // R12: stray command with different fields while busy
            cmd_valid = (($urandom % 6) == 0);
            cmd_x0 = 16'($urandom % 64); cmd_width = 16'(1 + $urandom % 4);
            cmd_bypass = ~byp;
            #1;
            check(addr_valid && !cmd_ready, "R2/R12", "valid while busy", addr_valid, 1);
            begin
                int ex = x0 + k % w;
                int ey = y0 + k / w;
                if (held) begin
                    check(tiled_addr == hold_t && lin_addr == hold_l && addr_last == hold_last,
                          "R8", "stalled beat changed", tiled_addr, hold_t);
                end
                check(tiled_addr == 32'(exp_tiled(ex, ey, tp, bpp, byp)),
                      byp ? "R10" : "R3/R4/R11", "tiled_addr",
                      tiled_addr, exp_tiled(ex, ey, tp, bpp, byp));
                check(lin_addr == 32'((ey - y0) * lp + bpp * (ex - x0)), "R5", "lin_addr",
                      lin_addr, (ey - y0) * lp + bpp * (ex - x0));
                check(addr_last == (k == total - 1), "R2", "addr_last",
                      addr_last, (k == total - 1));
            end
            if (addr_ready) begin
                k++; held = 1'b0;
            end else begin
                held = 1'b1; hold_t = tiled_addr; hold_l = lin_addr; hold_last = addr_last;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0; addr_ready = 1'b0;
        #1;
        check(addr_done == 1'b1, "R9", "done after last", addr_done, 1);
        check(cmd_ready == 1'b1 && addr_valid == 1'b0, "R9", "idle with done", cmd_ready, 1);
        @(negedge clk); #1;
        check(addr_done == 1'b0, "R9", "done one cycle", addr_done, 0);
    endtask

    // Send a command that must be refused and confirm no beats follow.
    task automatic bad_cmd(input int w, input int h, input int bpp, input string req);
        @(negedge clk);
        cmd_x0 = 16'd3; cmd_y0 = 16'd5;
        cmd_width = 16'(w); cmd_height = 16'(h);
        cmd_tile_pitch = 24'd256; cmd_lin_pitch = 24'd64;
        cmd_bpp = 5'(bpp); cmd_bypass = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check(cmd_err == 1'b1, req, "err pulse", cmd_err, 1);
        check(addr_valid == 1'b0, req, "no beat on refuse", addr_valid, 0);
        repeat (3) begin
            @(negedge clk); #1;
            check(cmd_err == 1'b0 && addr_valid == 1'b0 && cmd_ready == 1'b1,
                  req, "quiet after refuse", {cmd_err, addr_valid}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(!addr_valid && !addr_done && !cmd_err && cmd_ready, "R1", "in reset",
              {addr_valid, addr_done, cmd_err, cmd_ready}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!addr_valid && !addr_done && !cmd_err && cmd_ready, "R1", "after reset",
              {addr_valid, addr_done, cmd_err, cmd_ready}, 1);

        // Directed corners
        run_region(0, 0, 16, 16, 16 * 4 * 4, 64, 4, 1'b0, 0);       // R3 full aligned tile
        run_region(5, 3, 27, 4, 48 * 2, 54, 2, 1'b0, 30);            // R11 unaligned
        run_region(14, 15, 5, 3, 32 * 3, 15, 3, 1'b0, 50);           // R11 tile edges in X and Y
        run_region(7, 9, 1, 1, 100, 10, 16, 1'b0, 20);               // R2 single pixel
        run_region(0, 0, 20, 18, 32 * 12, 240, 12, 1'b1, 25);        // R10 bypass
        run_region(30, 2, 1, 20, 64, 8, 1, 1'b0, 40);                // single column
        run_region(1, 40, 33, 1, 48 * 6, 198, 6, 1'b0, 40);          // single row

        bad_cmd(4, 4, 5, "R6");
        bad_cmd(4, 4, 0, "R6");
        bad_cmd(4, 4, 17, "R6");
        bad_cmd(0, 4, 4, "R7");
        bad_cmd(4, 0, 4, "R7");

        // Random regions
        for (int n = 0; n < 30; n++) begin
            int w = 1 + $urandom % 36;
            int h = 1 + $urandom % 12;
            int x0 = $urandom % 64;
            int y0 = $urandom % 64;
            int bpp = pick_bpp($urandom);
            int tp = ((x0 + w) / 16 + 1) * 16 * bpp + 16 * ($urandom % 4);
            int lp = w * bpp + ($urandom % 32);
            run_region(x0, y0, w, h, tp, lp, bpp, bit'($urandom % 4 == 0), $urandom % 60);
        end

        finish_run();
    end

endmodule